// File: doc/BRIEF.md
# Break-Even Threshold Calibrator

This block fills a power manager's idle-time threshold registers with values worked out for the chip it sits on, so the thresholds do not have to be fixed when the design is signed off. Each power state has a slot. Slot 0 is the Active state. Slots 1 to NS are the low-power states, ordered from shallowest to deepest. A slot holds:

- a dynamic in-state power;
- a leakage fraction;
- a transition power, measured from Active;
- a transition time.

A speed-bin index gives an estimated total leakage for the chip. The block adds each state's share of that leakage to the state's dynamic power. It then works out, for every pair of adjacent states, the idle time at which the deeper state starts to cost less energy.

Software or a boot sequencer loads the slots through the load port, sets the bin index and pulses `start`. The block then computes the thresholds one after another, from the shallowest state to the deepest, using a one-bit-per-cycle restoring divider. All thresholds, per-entry error bits and ordering flags are written together in the cycle in which `done` pulses. Transition energy is counted as the transition power minus the target state's dynamic power, times the transition time. Leakage during a transition is taken to equal the target state's in-state leakage, so leakage enters only through the denominators.

Top module: `brk_even_cal`

## Requirements
- R1: After synchronous reset:
  - every threshold entry, every bit of `err_flags` and every bit of `mono_flags` is 0;
  - `busy` and `done` are 0.
- R2: The leakage estimate is `leak = LEAK_BASE + bin*LEAK_STEP`, using the bin index taken when `start` is accepted.
  - State power is `P[s] = dyn[s] + floor(frac[s]*leak / 2^FW)`.
  - Entry k (k = 1..NS) is `floor((E[k] - E[k-1]) / (P[k-1] - P[k]))`, where `E[s] = (ptr[s] - dyn[s]) * ttr[s]` for s ≥ 1 and `E[0] = 0`.
  - Entry k sits in `thr_out[(k-1)*THW +: THW]`.
- R3: The transition power and transition time loaded into slot 0 (Active) have no effect on any result.
- R4: When slots 0 and 1 have the same leakage fraction, entry 1 has the same value for every bin index.
- R5: If `P[k-1] - P[k] <= 0`, or if `E[k] - E[k-1] < 0`, then bit k-1 of `err_flags` is set and entry k is all ones.
- R6: A quotient that does not fit in THW bits gives an all-ones entry, and bit k-1 of `err_flags` stays clear.
- R7: Non-monotonic results are flagged but not changed.
  - Bit k-1 of `mono_flags` is set, for k ≥ 2, exactly when entry k < entry k-1.
  - Bit 0 is always 0.
  - The entries themselves are left as computed.
- R8: `thr_out`, `err_flags` and `mono_flags` keep their previous values until the cycle in which `done` is high, and they all change together in that cycle.
- R9: Handshake behaviour:
  - `busy` rises on the cycle after an accepted `start`.
  - `done` is a single-cycle pulse, high in the cycle in which `busy` returns low.
  - A `start` raised while `busy` is high is ignored.
- R10: Counted in clock edges after the edge that accepts `start`, `done` rises after `1 + sum(cost_k)` edges.
  - `cost_k = 1` for an entry in error.
  - `cost_k = NW+2` otherwise, where `NW = PW+TW+2`.
- R11: A change of `bin_idx` while `busy` is high does not affect the run in progress.
- R12: `ld_en` is ignored while `busy` is high: the slot contents stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run (accepted when idle) |
| ld_en | input | 1 | Write the load fields into slot `ld_slot` |
| ld_slot | input | SW | Slot index: 0 = Active, 1..NS = low-power states |
| ld_dyn | input | PW | Dynamic in-state power |
| ld_frac | input | FW | Leakage fraction, in units of 1/2^FW |
| ld_ptr | input | PW | Transition power from Active |
| ld_ttr | input | TW | Transition time from Active |
| bin_idx | input | BW | Speed-bin index |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| thr_out | output | NS*THW | Threshold register file; entry k at `[(k-1)*THW +: THW]` |
| err_flags | output | NS | Per-entry error bits |
| mono_flags | output | NS | Per-entry ordering-violation bits |

## Verification
Every result of a run is due together, in the cycle in which `done` rises. For a run with no errored entries, that is `NS*(NW+2)+1` edges after the accepting edge (109 with the default parameters). Each errored entry shortens the run by `NW+1` edges.

The driver counts edges from the accepting edge and compares the count with the figure predicted from its own model's error bits. It pushes the expected entries and flags into a queue before raising `start`. A monitor pops and compares them only on the falling edge in which `done` is seen, so each result is sampled half a cycle after the edge that commits it.

While a run is in progress, the driver also checks that `busy` is high and that the previous outputs are still held. It checks that `done` is low again on the following cycle.

// File: rtl/brk_pkg.sv
// Shared types and helpers for the break-even threshold calibrator.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package brk_pkg;

    // Sequencer states of the calibration run.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_COMMIT
    } cal_st_t;

    // Leakage estimate for a speed bin: a linear correlation curve.
    function automatic int unsigned bin_leak(int unsigned bin,
                                             int unsigned base,
                                             int unsigned step);
        return base + bin * step;
    endfunction

endpackage

// File: rtl/brk_leak_table.sv
// Speed-bin to leakage lookup.
// Holds one entry per bin, each computed from the base/step parameters.
// Assumes: base + (2^BW - 1)*step fits in PW bits.
module brk_leak_table #(
    parameter int          BW        = 2,
    parameter int          PW        = 16,
    parameter int unsigned LEAK_BASE = 100,
    parameter int unsigned LEAK_STEP = 200
) (
    input  logic [BW-1:0] bin,
    output logic [PW-1:0] leak
);
    localparam int NB = 1 << BW;

    logic [PW-1:0] tab [NB];

    // One table entry per bin, evaluated at elaboration.
    for (genvar b = 0; b < NB; b++) begin : g_bin
        assign tab[b] = PW'(brk_pkg::bin_leak(b, LEAK_BASE, LEAK_STEP));
    end

    assign leak = tab[bin];

endmodule

// File: rtl/brk_operands.sv
// Forms the signed numerator and denominator of one break-even quotient.
// Side a is the shallower state and side b the deeper one.
// Flags a pair that cannot give a valid threshold.
// Assumes: the caller zeroes the transition fields of the Active state.
module brk_operands #(
    parameter int PW = 16,
    parameter int TW = 16,
    parameter int FW = 8
) (
    input  logic [PW-1:0]      dyn_a,
    input  logic [FW-1:0]      frac_a,
    input  logic [PW-1:0]      ptr_a,
    input  logic [TW-1:0]      ttr_a,
    input  logic [PW-1:0]      dyn_b,
    input  logic [FW-1:0]      frac_b,
    input  logic [PW-1:0]      ptr_b,
    input  logic [TW-1:0]      ttr_b,
    input  logic [PW-1:0]      leak,
    output logic [PW+TW+1:0]   num_mag,
    output logic [PW:0]        den_mag,
    output logic               bad
);
    localparam int NW = PW + TW + 2;

    logic [FW+PW-1:0]  lk_a, lk_b;
    logic [PW:0]       pw_a, pw_b;
    logic signed [PW:0]   dt_a, dt_b;
    logic [NW-1:0]     dx_a, dx_b, tx_a, tx_b;
    logic signed [NW-1:0] tm_a, tm_b;
    logic signed [NW:0]   num;
    logic signed [PW+1:0] den;

    // State powers: dynamic part plus the state's share of leakage.
    always_comb begin
        lk_a = {{PW{1'b0}}, frac_a} * {{FW{1'b0}}, leak};
        lk_b = {{PW{1'b0}}, frac_b} * {{FW{1'b0}}, leak};
        pw_a = {1'b0, dyn_a} + (PW+1)'(lk_a >> FW);
        pw_b = {1'b0, dyn_b} + (PW+1)'(lk_b >> FW);
    end

    // Transition energy terms (ptr - dyn) * ttr, signed.
    always_comb begin
        dt_a = $signed({1'b0, ptr_a}) - $signed({1'b0, dyn_a});
        dt_b = $signed({1'b0, ptr_b}) - $signed({1'b0, dyn_b});
        dx_a = {{(TW+1){dt_a[PW]}}, dt_a};
        dx_b = {{(TW+1){dt_b[PW]}}, dt_b};
        tx_a = {{(PW+2){1'b0}}, ttr_a};
        tx_b = {{(PW+2){1'b0}}, ttr_b};
        tm_a = $signed(dx_a) * $signed(tx_a);
        tm_b = $signed(dx_b) * $signed(tx_b);
    end

    // Quotient operands and the validity test.
    always_comb begin
        num     = $signed({tm_b[NW-1], tm_b}) - $signed({tm_a[NW-1], tm_a});
        den     = $signed({1'b0, pw_a}) - $signed({1'b0, pw_b});
        bad     = den[PW+1] || (den == '0) || num[NW];
        num_mag = num[NW-1:0];
        den_mag = den[PW:0];
    end

endmodule

// File: rtl/brk_rdiv.sv
// Radix-2 restoring divider, one quotient bit per cycle.
// Pulse go with the operands.
// After NW iteration cycles, valid pulses for one cycle; quo holds the result until the next go.
// Assumes: den is non-zero whenever go is raised.
module brk_rdiv #(
    parameter int NW = 34,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo,
    output logic          valid
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] q;
    logic [DW-1:0] rem, dv;
    logic [CW-1:0] cnt;
    logic          run;
    logic [DW:0]   trial, diff;
    logic          ge;

    // Trial subtraction of the shifted partial remainder.
    always_comb begin
        trial = {rem, q[NW-1]};
        diff  = trial - {1'b0, dv};
        ge    = !diff[DW];
    end

    // Iteration register: load on go, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            rem   <= '0;
            dv    <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                q   <= num;
                rem <= '0;
                dv  <= den;
                cnt <= CW'(NW);
                run <= 1'b1;
            end else if (run) begin
                q   <= {q[NW-2:0], ge};
                rem <= ge ? diff[DW-1:0] : trial[DW-1:0];
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run   <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quo = q;

endmodule

// File: rtl/brk_even_cal.sv
// Break-even threshold calibrator (top).
// Holds the per-state parameter slots and takes a leakage estimate from the speed bin.
// Computes entries 1..NS in order, then commits all results at once with a done pulse.
// Assumes: slot 0 is Active; slots 1..NS are ordered from shallowest to deepest.
module brk_even_cal
    import brk_pkg::*;
#(
    parameter int          NS        = 3,
    parameter int          PW        = 16,
    parameter int          TW        = 16,
    parameter int          FW        = 8,
    parameter int          BW        = 2,
    parameter int          THW       = 24,
    parameter int unsigned LEAK_BASE = 100,
    parameter int unsigned LEAK_STEP = 200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    ld_en,
    input  logic [$clog2(NS+1)-1:0] ld_slot,
    input  logic [PW-1:0]           ld_dyn,
    input  logic [FW-1:0]           ld_frac,
    input  logic [PW-1:0]           ld_ptr,
    input  logic [TW-1:0]           ld_ttr,
    input  logic [BW-1:0]           bin_idx,
    output logic                    busy,
    output logic                    done,
    output logic [NS*THW-1:0]       thr_out,
    output logic [NS-1:0]           err_flags,
    output logic [NS-1:0]           mono_flags
);
    localparam int SW    = $clog2(NS + 1);
    localparam int NSLOT = 1 << SW;
    localparam int NW    = PW + TW + 2;
    localparam int DW    = PW + 1;

    cal_st_t       st;
    logic [SW-1:0] k, ka;
    logic [PW-1:0] leak_est, leak_q;

    logic [PW-1:0] dyn_r  [NSLOT];
    logic [FW-1:0] frac_r [NSLOT];
    logic [PW-1:0] ptr_r  [NSLOT];
    logic [TW-1:0] ttr_r  [NSLOT];

    logic [THW-1:0] stg_thr [NS];
    logic [NS-1:0]  stg_err;
    logic [NS-1:0]  mono_n;

    logic [PW-1:0]  ptr_a;
    logic [TW-1:0]  ttr_a;
    logic [NW-1:0]  num_mag, quo;
    logic [DW-1:0]  den_mag;
    logic           bad, div_go, div_valid, last;
    logic [THW-1:0] sat_q;

    brk_leak_table #(
        .BW(BW), .PW(PW), .LEAK_BASE(LEAK_BASE), .LEAK_STEP(LEAK_STEP)
    ) u_tab (
        .bin (bin_idx),
        .leak(leak_est)
    );

    // Operand selection for the pair (k-1, k); Active has no transition cost.
    always_comb begin
        ka    = k - SW'(1);
        ptr_a = (ka == '0) ? '0 : ptr_r[ka];
        ttr_a = (ka == '0) ? '0 : ttr_r[ka];
        last  = (k == SW'(NS));
    end

    brk_operands #(.PW(PW), .TW(TW), .FW(FW)) u_ops (
        .dyn_a  (dyn_r[ka]),
        .frac_a (frac_r[ka]),
        .ptr_a  (ptr_a),
        .ttr_a  (ttr_a),
        .dyn_b  (dyn_r[k]),
        .frac_b (frac_r[k]),
        .ptr_b  (ptr_r[k]),
        .ttr_b  (ttr_r[k]),
        .leak   (leak_q),
        .num_mag(num_mag),
        .den_mag(den_mag),
        .bad    (bad)
    );

    assign div_go = (st == ST_PREP) && !bad;

    brk_rdiv #(.NW(NW), .DW(DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (num_mag),
        .den  (den_mag),
        .quo  (quo),
        .valid(div_valid)
    );

    // Clamp quotients that do not fit the threshold width.
    assign sat_q = (|quo[NW-1:THW]) ? '1 : quo[THW-1:0];

    // Ordering flags over the staged entries; the first entry has no predecessor.
    assign mono_n[0] = 1'b0;
    for (genvar i = 1; i < NS; i++) begin : g_mono
        assign mono_n[i] = stg_thr[i] < stg_thr[i-1];
    end

    // Parameter slot storage, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                dyn_r[s]  <= '0;
                frac_r[s] <= '0;
                ptr_r[s]  <= '0;
                ttr_r[s]  <= '0;
            end
        end else if (ld_en && st == ST_IDLE) begin
            dyn_r[ld_slot]  <= ld_dyn;
            frac_r[ld_slot] <= ld_frac;
            ptr_r[ld_slot]  <= ld_ptr;
            ttr_r[ld_slot]  <= ld_ttr;
        end
    end

    // Run sequencer: stage each entry, then commit every result together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            k          <= '0;
            leak_q     <= '0;
            done       <= 1'b0;
            thr_out    <= '0;
            err_flags  <= '0;
            mono_flags <= '0;
            stg_err    <= '0;
            for (int i = 0; i < NS; i++) stg_thr[i] <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        leak_q <= leak_est;
                        k      <= SW'(1);
                        st     <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (bad) begin
                        stg_thr[ka] <= '1;
                        stg_err[ka] <= 1'b1;
                        if (last) st <= ST_COMMIT;
                        else begin
                            k  <= k + SW'(1);
                            st <= ST_PREP;
                        end
                    end else begin
                        st <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_valid) begin
                        stg_thr[ka] <= sat_q;
                        stg_err[ka] <= 1'b0;
                        if (last) st <= ST_COMMIT;
                        else begin
                            k  <= k + SW'(1);
                            st <= ST_PREP;
                        end
                    end
                end
                ST_COMMIT: begin
                    for (int i = 0; i < NS; i++) thr_out[i*THW +: THW] <= stg_thr[i];
                    err_flags  <= stg_err;
                    mono_flags <= mono_n;
                    done       <= 1'b1;
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

endmodule

// File: rtl/brk_even_cal_chk.sv
// Property checker for the break-even threshold calibrator, bound to the top.
// Observes only the top-level ports.
module brk_even_cal_chk #(
    parameter int NS  = 3,
    parameter int THW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [NS*THW-1:0] thr_out,
    input logic [NS-1:0]     err_flags,
    input logic [NS-1:0]     mono_flags
);
    // R9: completion lasts one cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy has dropped when done is shown.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: an accepted start raises busy on the next cycle.
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: results hold during a run except at the commit.
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || $stable(thr_out)));

    // R8: results hold while idle.
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(thr_out));

    // R7: the first entry never carries an ordering flag.
    p_mono_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mono_flags[0]);

    for (genvar i = 0; i < NS; i++) begin : g_ent
        // R5: an errored entry reads all ones.
        p_sat_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
            err_flags[i] |-> (thr_out[i*THW +: THW] == {THW{1'b1}}));
    end

    for (genvar i = 1; i < NS; i++) begin : g_ord
        // R7: a flag marks exactly a decrease against the previous entry.
        p_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mono_flags[i] == (thr_out[i*THW +: THW] < thr_out[(i-1)*THW +: THW]));
    end

endmodule

bind brk_even_cal brk_even_cal_chk #(.NS(NS), .THW(THW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .thr_out   (thr_out),
    .err_flags (err_flags),
    .mono_flags(mono_flags)
);

// File: tb/sim_brk_even_cal.sv
// Scoreboard bench for the break-even threshold calibrator.
// The driver pushes expected results computed from the requirements.
// The monitor pops and compares them when done is seen.
`timescale 1ns/1ps
module sim_brk_even_cal;
    localparam int NS  = 3;
    localparam int PW  = 16;
    localparam int TW  = 16;
    localparam int FW  = 8;
    localparam int BW  = 2;
    localparam int THW = 24;
    localparam int NW  = PW + TW + 2;
    localparam longint TMAX = (64'd1 << THW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              ld_en = 1'b0;
    logic [1:0]        ld_slot = '0;
    logic [PW-1:0]     ld_dyn = '0;
    logic [FW-1:0]     ld_frac = '0;
    logic [PW-1:0]     ld_ptr = '0;
    logic [TW-1:0]     ld_ttr = '0;
    logic [BW-1:0]     bin_idx = '0;
    logic              busy, done;
    logic [NS*THW-1:0] thr_out;
    logic [NS-1:0]     err_flags, mono_flags;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NS*THW-1:0] thr;
        logic [NS-1:0]     err;
        logic [NS-1:0]     mono;
        string             req;
    } exp_t;
    exp_t sb_q[$];

    longint m_dyn [4], m_frac [4], m_ptr [4], m_ttr [4];
    logic [NS*THW-1:0] prev_thr = '0;

    brk_even_cal u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_slot(ld_slot),
        .ld_dyn(ld_dyn), .ld_frac(ld_frac), .ld_ptr(ld_ptr), .ld_ttr(ld_ttr),
        .bin_idx(bin_idx), .busy(busy), .done(done), .thr_out(thr_out),
        .err_flags(err_flags), .mono_flags(mono_flags)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Expected results from the requirement formulas (R2, R3, R5, R6, R7).
    function automatic exp_t model(int bin, string req);
        exp_t   e;
        longint leak, p [4], en [4], num, den, q;
        longint t [NS];
        leak = 100 + bin * 200;
        for (int s = 0; s < 4; s++) begin
            p[s]  = m_dyn[s] + ((m_frac[s] * leak) >> FW);
            en[s] = (s == 0) ? 0 : (m_ptr[s] - m_dyn[s]) * m_ttr[s];
        end
        e.err = '0;
        e.mono = '0;
        for (int k = 1; k <= NS; k++) begin
            num = en[k] - en[k-1];
            den = p[k-1] - p[k];
            if (den <= 0 || num < 0) begin
                t[k-1] = TMAX;
                e.err[k-1] = 1'b1;
            end else begin
                q = num / den;
                t[k-1] = (q > TMAX) ? TMAX : q;
            end
            e.thr[(k-1)*THW +: THW] = THW'(t[k-1]);
        end
        for (int k = 1; k < NS; k++) e.mono[k] = (t[k] < t[k-1]);
        e.req = req;
        return e;
    endfunction

    task automatic load_slot(input int s, input longint dyn, input longint frac,
                             input longint ptr, input longint ttr);
        @(negedge clk);
        ld_en = 1'b1; ld_slot = 2'(s);
        ld_dyn = PW'(dyn); ld_frac = FW'(frac); ld_ptr = PW'(ptr); ld_ttr = TW'(ttr);
        m_dyn[s] = dyn; m_frac[s] = frac; m_ptr[s] = ptr; m_ttr[s] = ttr;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Driver: push the expectation, start, count edges to done (R10), optionally disturb (R8, R9, R11, R12).
    task automatic run_cal(input int bin, input bit disturb, input string req);
        exp_t e;
        int   cnt, exp_cyc;
        e = model(bin, req);
        exp_cyc = 1;
        for (int k = 0; k < NS; k++) exp_cyc += e.err[k] ? 1 : NW + 2;
        sb_q.push_back(e);
        @(negedge clk);
        bin_idx = BW'(bin);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (disturb && cnt == 3) begin
                chk(busy === 1'b1, "R9", "busy mid-run", longint'(busy), 1);
                chk(thr_out === prev_thr, "R8", "hold mid-run",
                    longint'(thr_out[THW-1:0]), longint'(prev_thr[THW-1:0]));
                bin_idx = '0;          // R11 disturbance
                start = 1'b1;          // R9 ignored start
                ld_en = 1'b1;          // R12 ignored load
                ld_slot = 2'd1; ld_dyn = 16'd7; ld_frac = 8'd0; ld_ptr = 16'd9; ld_ttr = 16'd1;
            end
            if (disturb && cnt == 4) begin
                start = 1'b0;
                ld_en = 1'b0;
            end
        end while (!done && cnt < 2000);
        chk(cnt == exp_cyc, "R10", "edges to done", cnt, exp_cyc);
        prev_thr = thr_out;
        @(negedge clk);
        chk(done === 1'b0, "R9", "done single pulse", longint'(done), 0);
        chk(busy === 1'b0, "R9", "idle after done", longint'(busy), 0);
    endtask

    // Monitor: compare each commit against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                for (int k = 0; k < NS; k++)
                    chk(thr_out[k*THW +: THW] === e.thr[k*THW +: THW], e.req, "threshold entry",
                        longint'(thr_out[k*THW +: THW]), longint'(e.thr[k*THW +: THW]));
                chk(err_flags === e.err, e.req, "err_flags", longint'(err_flags), longint'(e.err));
                chk(mono_flags === e.mono, e.req, "mono_flags", longint'(mono_flags), longint'(e.mono));
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [THW-1:0] first_b0, first_b3;
        for (int s = 0; s < 4; s++) begin
            m_dyn[s] = 0; m_frac[s] = 0; m_ptr[s] = 0; m_ttr[s] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(thr_out === '0, "R1", "thr_out after reset", longint'(thr_out[THW-1:0]), 0);
        chk(err_flags === '0, "R1", "err_flags after reset", longint'(err_flags), 0);
        chk(mono_flags === '0, "R1", "mono_flags after reset", longint'(mono_flags), 0);
        chk(busy === 1'b0, "R1", "busy after reset", longint'(busy), 0);
        chk(done === 1'b0, "R1", "done after reset", longint'(done), 0);

        // Config A: Active and S1 share a leakage fraction.
        load_slot(0, 1000, 200, 0, 0);
        load_slot(1, 400, 200, 1500, 10);
        load_slot(2, 50, 20, 3000, 200);
        load_slot(3, 5, 2, 5000, 1000);
        run_cal(0, 1'b0, "R2");
        first_b0 = thr_out[THW-1:0];
        run_cal(3, 1'b0, "R2");
        first_b3 = thr_out[THW-1:0];
        chk(first_b0 == first_b3, "R4", "entry 1 across bins", longint'(first_b3), longint'(first_b0));

        // R3: Active transition fields loaded non-zero are ignored (model keeps them out).
        load_slot(0, 1000, 200, 999, 77);
        run_cal(1, 1'b0, "R3");
        chk(thr_out[THW-1:0] == first_b0, "R3", "entry 1 with Active transition data",
            longint'(thr_out[THW-1:0]), longint'(first_b0));

        // R8, R9, R11, R12: disturbed run with bin 2, then a clean repeat.
        run_cal(2, 1'b1, "R11");
        run_cal(2, 1'b0, "R12");

        // Config B: R5 negative denominator (entry 2) and negative numerator (entry 3).
        load_slot(0, 1000, 0, 0, 0);
        load_slot(1, 500, 0, 2000, 10);
        load_slot(2, 600, 0, 700, 10);
        load_slot(3, 100, 0, 150, 5);
        run_cal(0, 1'b0, "R5");

        // Config C: R7 decreasing entry 2, R6 saturated entry 3.
        load_slot(1, 100, 0, 1100, 100);
        load_slot(2, 10, 0, 1010, 105);
        load_slot(3, 9, 0, 65535, 65535);
        run_cal(1, 1'b0, "R6");
        chk(mono_flags[1] === 1'b1, "R7", "decrease flagged", longint'(mono_flags[1]), 1);
        chk(err_flags[2] === 1'b0 && thr_out[2*THW +: THW] == TMAX[THW-1:0], "R6",
            "saturated entry without error", longint'(thr_out[2*THW +: THW]), TMAX);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R8", "pending expectations", sb_q.size(), 0);
        finish_run();
    end

endmodule